// File: doc/BRIEF.md
# Asynchronous DRAM Cycle Sequencer

This block connects a simple synchronous request port to a 64K x 1 asynchronous DRAM built as 256 rows by 256 columns. A host asks for a one-bit read or write at a 16-bit address. The sequencer then splits that address onto an 8-bit multiplexed bus, row half first and column half second. It drives the active-low row strobe, column strobe and write enable in the order that the requested cycle needs. For a read, it captures the bit that the memory returns.

The memory's stored charge decays, so every row has to be refreshed. A refresh timer raises a pending flag at a fixed interval. At the next idle point the sequencer runs a row-strobe-only cycle on the row named by an internal 8-bit counter, and then moves the counter on. A pending refresh wins over a waiting host request. A cycle that has already started always runs to its end.

The controller is a single state machine. Its states are:
- IDLE: waiting.
- ROW: row address set up on the bus.
- RAS: row strobe low.
- COL: column address set up on the bus.
- WE: write enable low.
- CAS: column strobe low.
- WE_OFF: write enable released.
- RAS_OFF: row strobe released.
- PRE: all strobes high.

Every state other than IDLE lasts PHASE_CLKS clocks. The transitions are:
- Refresh: IDLE→ROW→RAS→PRE→IDLE.
- Read: IDLE→ROW→RAS→COL→CAS→RAS_OFF→PRE→IDLE.
- Write: IDLE→ROW→RAS→COL→WE→CAS→WE_OFF→RAS_OFF→PRE→IDLE.

IDLE goes to ROW when a refresh is pending, or else when a request is valid.

Top module: `dram_cycle_seq`

## Requirements
- R1: While reset is asserted and after its release, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high (inactive), and `busy`, `done` and `rdata` are 0.
- R2: The row address is `req_addr[15:8]` and the column address is `req_addr[7:0]`. The row address is on `dram_addr` for at least one full clock before `dram_ras_n` falls. The column address is on `dram_addr` for at least one full clock before `dram_cas_n` falls.
- R3: A refresh cycle drives `dram_ras_n` low and then high while `dram_cas_n` and `dram_we_n` stay high throughout.
- R4: A read cycle runs in this order: RAS falls, then CAS falls, then RAS rises, then CAS rises. `rdata` takes the bit that the memory drives while CAS is low.
- R5: A write cycle runs in this order: RAS falls, then WE falls with `dram_din` already equal to the request data, then CAS falls, then WE rises, then RAS rises, then CAS rises.
- R6: The refresh row counter starts at 0, supplies the row address of each refresh, and increments by one after each refresh, wrapping from 255 to 0.
- R7: A refresh becomes pending every REF_INTERVAL clocks after reset. In IDLE a pending refresh starts before a valid host request. A refresh never interrupts a read or write in progress.
- R8: `busy` is 1 in every clock of a refresh, read or write cycle and 0 in IDLE. `done` is a one-clock pulse in the first idle clock after a read or write, and never follows a refresh. `rdata` holds its value from that pulse until the next read completes.
- R9: A request is taken only in IDLE with no refresh pending, and its address and data are sampled at that clock; later changes to `req_addr` or `req_wdata` do not affect the cycle. Each non-idle state lasts exactly PHASE_CLKS clocks (PHASE_CLKS ≥ 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present; held until `done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*ADDR_HALF | Bit address: upper half row, lower half column |
| req_wdata | input | 1 | Bit to write |
| busy | output | 1 | A memory cycle is running |
| done | output | 1 | One-clock completion pulse for a read or write |
| rdata | output | 1 | Last bit read |
| dram_addr | output | ADDR_HALF | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | 1 | Data into the memory |
| dram_dout | input | 1 | Data from the memory |

## Verification
The assertions assume the following about the host:
- It holds `req_valid` steady from the moment it raises it until it sees `done`.
- It lowers `req_valid` before the next clock edge after `done`.
- It changes its inputs only away from the active edge.

The bench drives every input one nanosecond after a rising edge and drops the request within the `done` clock. It deliberately alters the address and data while a cycle runs, to show that only the values sampled at acceptance count. The memory model returns data only while the column strobe is low with write enable high, so the read capture is exercised within the window the sequencer provides.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ROW,
        S_RAS,
        S_COL,
        S_WE,
        S_CAS,
        S_WE_OFF,
        S_RAS_OFF,
        S_PRE
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_REF,
        OP_RD,
        OP_WR
    } op_kind_t;

endpackage

// File: rtl/dram_phase_count.sv
module dram_phase_count #(
    parameter int PHASE_CLKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(PHASE_CLKS + 1);

    logic [CW-1:0] cnt;

    assign last = (cnt == CW'(PHASE_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9: every cycle starts its first phase from a fresh count
    a_r9_phase_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt == '0));

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int INTERVAL = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic pending
);
    localparam int TW = $clog2(INTERVAL + 1);

    logic [TW-1:0] tick;
    logic          wrap;

    assign wrap = (tick == TW'(INTERVAL - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick    <= '0;
            pending <= 1'b0;
        end else begin
            tick <= wrap ? '0 : tick + 1'b1;
            if (wrap) begin
                pending <= 1'b1;
            end else if (take) begin
                pending <= 1'b0;
            end
        end
    end

    // R7: a pending refresh is kept until it is served
    a_r7_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !take |=> pending);

    // R7: serving clears the flag unless a new interval ends at once
    a_r7_pending_served: assert property (@(posedge clk) disable iff (!rst_n)
        take && !wrap |=> !pending);

endmodule

// File: rtl/dram_row_counter.sv
module dram_row_counter #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
        end else if (bump) begin
            row <= row + 1'b1;
        end
    end

    // R6: step by one with natural wrap
    a_r6_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        bump |=> (row == $past(row) + 1'b1));

    // R6: no movement without a finished refresh
    a_r6_row_still: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> $stable(row));

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       ref_pending,
    input  logic       phase_last,
    output seq_state_t state,
    output op_kind_t   op,
    output logic       take_ref,
    output logic       take_req,
    output logic       bump_row,
    output logic       end_host,
    output logic       cas_read_end,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output logic       col_sel
);
    seq_state_t nxt;
    op_kind_t   nxt_op;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            op    <= OP_REF;
        end else begin
            state <= nxt;
            op    <= nxt_op;
        end
    end

    // transitions
    always_comb begin
        nxt    = state;
        nxt_op = op;
        unique case (state)
            S_IDLE: begin
                if (ref_pending) begin
                    nxt    = S_ROW;
                    nxt_op = OP_REF;
                end else if (req_valid) begin
                    nxt    = S_ROW;
                    nxt_op = req_write ? OP_WR : OP_RD;
                end
            end
            S_ROW:     if (phase_last) nxt = S_RAS;
            S_RAS:     if (phase_last) nxt = (op == OP_REF) ? S_PRE : S_COL;
            S_COL:     if (phase_last) nxt = (op == OP_WR) ? S_WE : S_CAS;
            S_WE:      if (phase_last) nxt = S_CAS;
            S_CAS:     if (phase_last) nxt = (op == OP_WR) ? S_WE_OFF : S_RAS_OFF;
            S_WE_OFF:  if (phase_last) nxt = S_RAS_OFF;
            S_RAS_OFF: if (phase_last) nxt = S_PRE;
            S_PRE:     if (phase_last) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ras_n   = 1'b1;
        cas_n   = 1'b1;
        we_n    = 1'b1;
        col_sel = 1'b0;
        unique case (state)
            S_IDLE, S_ROW, S_PRE: ;
            S_RAS: ras_n = 1'b0;
            S_COL: begin
                ras_n   = 1'b0;
                col_sel = 1'b1;
            end
            S_WE: begin
                ras_n   = 1'b0;
                we_n    = 1'b0;
                col_sel = 1'b1;
            end
            S_CAS: begin
                ras_n   = 1'b0;
                cas_n   = 1'b0;
                we_n    = (op != OP_WR);
                col_sel = 1'b1;
            end
            S_WE_OFF: begin
                ras_n   = 1'b0;
                cas_n   = 1'b0;
                col_sel = 1'b1;
            end
            S_RAS_OFF: begin
                cas_n   = 1'b0;
                col_sel = 1'b1;
            end
            default: ;
        endcase
    end

    assign take_ref     = (state == S_IDLE) && ref_pending;
    assign take_req     = (state == S_IDLE) && !ref_pending && req_valid;
    assign bump_row     = (state == S_RAS) && phase_last && (op == OP_REF);
    assign end_host     = (state == S_PRE) && phase_last && (op != OP_REF);
    assign cas_read_end = (state == S_CAS) && phase_last && (op == OP_RD);

    // R7: pending refresh wins in IDLE
    a_r7_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) && ref_pending |=> (state == S_ROW) && (op == OP_REF));

    // R3: refresh never strobes a column or write
    a_r3_ras_only: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_REF) && (state != S_IDLE) |-> cas_n && we_n);

    // R9: a state is held until its phase ends
    a_r9_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) && !phase_last |=> (state == $past(state)));

    // R7: a running cycle keeps its kind
    a_r7_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(op));

endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
    import dram_seq_pkg::*;
#(
    parameter int ADDR_HALF    = 8,
    parameter int PHASE_CLKS   = 1,
    parameter int REF_INTERVAL = 512
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [2*ADDR_HALF-1:0] req_addr,
    input  logic                   req_wdata,
    output logic                   busy,
    output logic                   done,
    output logic                   rdata,
    output logic [ADDR_HALF-1:0]   dram_addr,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_din,
    input  logic                   dram_dout
);
    localparam int AW = 2 * ADDR_HALF;

    seq_state_t           state;
    op_kind_t             op;
    logic                 phase_last;
    logic                 ref_pending;
    logic                 take_ref;
    logic                 take_req;
    logic                 bump_row;
    logic                 end_host;
    logic                 cas_read_end;
    logic                 col_sel;
    logic [ADDR_HALF-1:0] ref_row;
    logic [AW-1:0]        lat_addr;
    logic                 lat_data;
    logic [ADDR_HALF-1:0] row_sel;

    dram_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .ref_pending  (ref_pending),
        .phase_last   (phase_last),
        .state        (state),
        .op           (op),
        .take_ref     (take_ref),
        .take_req     (take_req),
        .bump_row     (bump_row),
        .end_host     (end_host),
        .cas_read_end (cas_read_end),
        .ras_n        (dram_ras_n),
        .cas_n        (dram_cas_n),
        .we_n         (dram_we_n),
        .col_sel      (col_sel)
    );

    dram_phase_count #(.PHASE_CLKS(PHASE_CLKS)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .last  (phase_last)
    );

    dram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take_ref),
        .pending (ref_pending)
    );

    dram_row_counter #(.ROW_W(ADDR_HALF)) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (bump_row),
        .row   (ref_row)
    );

    assign busy = (state != S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_data <= 1'b0;
            done     <= 1'b0;
            rdata    <= 1'b0;
        end else begin
            if (take_req) begin
                lat_addr <= req_addr;
                lat_data <= req_wdata;
            end
            done <= end_host;
            if (cas_read_end) begin
                rdata <= dram_dout;
            end
        end
    end

    assign row_sel   = (op == OP_REF) ? ref_row : lat_addr[AW-1:ADDR_HALF];
    assign dram_addr = col_sel ? lat_addr[ADDR_HALF-1:0] : row_sel;
    assign dram_din  = lat_data;

    // R2: address settled before each strobe falls
    a_r2_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $stable(dram_addr));

    a_r2_col_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $stable(dram_addr));

    // R4: CAS only falls inside an open row
    a_r4_cas_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> !dram_ras_n && $past(!dram_ras_n));

    // R5: WE leads CAS on a write
    a_r5_we_leads: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) && !dram_we_n |-> $past(!dram_we_n));

    // R8: done is a single clock and only when idle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/test_dram_cycle_seq.sv
module test_dram_cycle_seq;
    localparam int PH = 2;
    localparam int RI = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_wdata = 1'b0;
    logic        busy, done, rdata;
    logic [7:0]  dram_addr;
    logic        ras_n, cas_n, we_n, dram_din;
    logic        dram_dout;

    always #2 clk = ~clk;

    dram_cycle_seq #(.ADDR_HALF(8), .PHASE_CLKS(PH), .REF_INTERVAL(RI)) i_dram_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .dram_addr(dram_addr), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
        .dram_we_n(we_n), .dram_din(dram_din), .dram_dout(dram_dout)
    );

    // behavioural memory array
    bit         cells [int];
    logic [7:0] m_row = '0, m_col = '0;
    logic       m_dout = 1'b0;
    assign dram_dout = m_dout;

    always @(negedge ras_n) m_row = dram_addr;
    always @(negedge cas_n) begin
        m_col = dram_addr;
        if (!we_n) cells[int'({m_row, m_col})] = dram_din;
        else m_dout = cells.exists(int'({m_row, m_col})) ? cells[int'({m_row, m_col})] : 1'b0;
    end
    always @(posedge cas_n) m_dout = 1'b0;

    // reference model
    typedef struct packed {
        logic       ras, cas, we, chk;
        logic [7:0] addr;
        logic [1:0] op;
        logic       last;
    } step_t;

    step_t q[$];
    bit    shadow [int];
    int    n_chk = 0, n_err = 0;
    int    p = 0, n_ref = 0, ref_row = 0;
    bit    pend = 0, done_due = 0, exp_done = 0;
    logic  exp_rdata = 1'b0, next_rdata = 1'b0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, p);
        end
    endtask

    task automatic ph(logic r, logic c, logic w, logic ck, logic [7:0] a, logic [1:0] o, bit lst);
        for (int k = 0; k < PH; k++) begin
            step_t s;
            s.ras = r; s.cas = c; s.we = w; s.chk = ck; s.addr = a; s.op = o;
            s.last = lst && (k == PH - 1);
            q.push_back(s);
        end
    endtask

    task automatic sched_ref(logic [7:0] row);
        ph(1, 1, 1, 1, row, 2'd0, 0);
        ph(0, 1, 1, 1, row, 2'd0, 0);
        ph(1, 1, 1, 0, row, 2'd0, 1);
    endtask

    task automatic sched_host(bit wr, logic [15:0] a);
        logic [1:0] o;
        o = wr ? 2'd2 : 2'd1;
        ph(1, 1, 1, 1, a[15:8], o, 0);
        ph(0, 1, 1, 1, a[15:8], o, 0);
        ph(0, 1, 1, 1, a[7:0], o, 0);
        if (wr) ph(0, 1, 0, 1, a[7:0], o, 0);
        ph(0, 0, !wr, 1, a[7:0], o, 0);
        if (wr) ph(0, 0, 1, 1, a[7:0], o, 0);
        ph(1, 0, 1, 1, a[7:0], o, 0);
        ph(1, 1, 1, 0, a[7:0], o, 1);
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            p = 0;
            chk(ras_n && cas_n && we_n, "R1", "strobes in reset", {ras_n, cas_n, we_n}, 7);
            chk(!busy && !done && !rdata, "R1", "busy/done/rdata in reset", {busy, done, rdata}, 0);
        end else begin
            p++;
            if (p % RI == 0) pend = 1;
            exp_done = done_due;
            done_due = 0;
            if (q.size() > 0) begin
                step_t s;
                string tg;
                s = q.pop_front();
                tg = (s.op == 2'd0) ? "R3 R7" : ((s.op == 2'd1) ? "R4 R9" : "R5 R9");
                chk(ras_n == s.ras, tg, "ras_n", ras_n, s.ras);
                chk(cas_n == s.cas, tg, "cas_n", cas_n, s.cas);
                chk(we_n == s.we, tg, "we_n", we_n, s.we);
                if (s.chk) chk(dram_addr == s.addr, (s.op == 2'd0) ? "R6" : "R2", "dram_addr", dram_addr, s.addr);
                chk(busy == 1'b1, "R8", "busy in cycle", busy, 1);
                chk(done == 1'b0, "R8", "done in cycle", done, 0);
                if (s.last && s.op != 2'd0) begin
                    done_due = 1;
                    if (s.op == 2'd1) exp_rdata = next_rdata;
                end
            end else begin
                chk(ras_n && cas_n && we_n, "R1", "strobes idle", {ras_n, cas_n, we_n}, 7);
                chk(busy == 1'b0, "R8", "busy idle", busy, 0);
                chk(done == exp_done, "R8", "done pulse", done, exp_done);
                chk(rdata == exp_rdata, "R4 R9", "rdata", rdata, exp_rdata);
                if (pend) begin
                    pend = 0;
                    sched_ref(8'(ref_row));
                    ref_row = (ref_row + 1) % 256;
                    n_ref++;
                end else if (req_valid) begin
                    if (req_write) shadow[int'(req_addr)] = req_wdata;
                    else next_rdata = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : 1'b0;
                    sched_host(req_write, req_addr);
                end
            end
        end
    end

    task automatic host_op(bit wr, logic [15:0] a, logic d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        if (busy) begin
            req_addr  = ~a;
            req_wdata = ~d;
        end
        while (!done) begin
            @(posedge clk); #1;
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        host_op(1, 16'h0000, 1'b1);
        host_op(1, 16'hFFFF, 1'b1);
        host_op(1, 16'hA55A, 1'b0);
        host_op(1, 16'h00FF, 1'b1);
        host_op(0, 16'h0000, 1'b0);
        host_op(0, 16'hFFFF, 1'b0);
        host_op(0, 16'hA55A, 1'b1);
        host_op(0, 16'h00FF, 1'b0);
        host_op(0, 16'h1234, 1'b0);
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            a = 16'(i * 40503 + 7);
            host_op(1, a, 1'(i ^ (i >> 2)));
            repeat (i % 9) @(posedge clk);
            host_op(0, a, 1'b0);
            repeat (i % 5) @(posedge clk);
        end
        repeat (4000) @(posedge clk);
        chk(n_ref >= 257, "R6", "refresh count covers row wrap", n_ref, 257);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule